// File: doc/BRIEF.md
# USB Transceiver Logic-Side Mode Multiplexer

This block sits between a system-side logic interface and the single-ended D+/D- line model of a USB full/low-speed transceiver. Two bidirectional system pins, called pin A and pin B, carry either a data/single-ended-zero pair or a direct per-line pair. A direction input chooses whether the system transmits onto the lines or observes them. The block also produces the differential receiver output, the slew-rate select and an effective suspend flag.

An 8-bit configuration word is loaded with a strobe. It selects the encoding and enables a serial pass-through mode and a general-purpose buffer mode. It chooses whether speed and suspend come from pins or from register bits, and it sets the per-line buffer direction. A remote wake-up request drives the K state onto the lines. This happens only when the block is suspended and full-speed is selected. Every output is registered on the system clock.

Top module: `usbx_mode_mux`

## Requirements
- R1: An asynchronous active-low reset clears the configuration word to 0 and drives every output to 0, including all enables, RCV, slew select and suspend. The configuration word bits are: [0] enc_dse (1 = data/SE0 encoding, 0 = direct VP/VM), [1] uart_en, [2] gp_en, [3] sw_ctl, [4] sw_spd, [5] sw_susp, [6] gp_dir_p, [7] gp_dir_m. Any level output whose enable is 0 reads 0.
- R2: When transmitting (dir_rx=0) with enc_dse=1, both line enables are 1. If pin B is 1, D+ and D- are both 0. Otherwise D+ equals pin A and D- equals its inverse.
- R3: When transmitting with enc_dse=0, both line enables are 1, D+ follows pin A and D- follows pin B.
- R4: When receiving (dir_rx=1) with enc_dse=1, both pin enables are 1. Pin A carries the RCV value and pin B is 1 only when D+ and D- are both 0.
- R5: When receiving with enc_dse=0, both pin enables are 1, pin A echoes D+ and pin B echoes D-.
- R6: RCV becomes 1 for D+=1 with D-=0 and becomes 0 for D+=0 with D-=1. For any other line state it keeps its previous value.
- R7: While suspend is in effect, RCV is 0. This takes priority over the hold rule in the same cycle.
- R8: With sw_ctl=0, slew_fs follows spd_pin and susp_out follows sus_pin. With sw_ctl=1, both pins are ignored and sw_spd and sw_susp are used instead (slew_fs=1 means 12 Mbps, 0 means 1.5 Mbps).
- R9: With uart_en=1, pin A is driven with D+ and D- is driven with pin B. D+ and pin B are not driven. This holds for either value of dir_rx.
- R10: Buffer mode applies only when gp_en=1, enc_dse=1, uart_en=0 and dir_rx=0. For each line, a direction bit of 1 drives the line from its pin, and 0 drives the pin from its line. A pin and its line are never driven together.
- R11: With wake_req=1, suspend in effect, full-speed selected and neither serial nor buffer mode active, the lines are driven to K (D+=0, D-=1). In any other case wake_req has no effect.
- R12: Outputs change on the first rising clock edge after an input change, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Loads cfg_word into the configuration register |
| cfg_word | input | 8 | Configuration word (fields in R1) |
| dir_rx | input | 1 | Direction: 0 transmit onto the lines, 1 receive |
| spd_pin | input | 1 | Hardware speed select |
| sus_pin | input | 1 | Hardware suspend request |
| wake_req | input | 1 | Remote wake-up request |
| pa_in | input | 1 | Pin A input level (data or VP) |
| pb_in | input | 1 | Pin B input level (SE0 or VM) |
| pa_out | output | 1 | Pin A driven level |
| pa_oe | output | 1 | Pin A drive enable |
| pb_out | output | 1 | Pin B driven level |
| pb_oe | output | 1 | Pin B drive enable |
| dp_in | input | 1 | Sensed D+ level |
| dm_in | input | 1 | Sensed D- level |
| dp_out | output | 1 | D+ driver level |
| dp_oe | output | 1 | D+ driver enable (0 = tri-state) |
| dm_out | output | 1 | D- driver level |
| dm_oe | output | 1 | D- driver enable (0 = tri-state) |
| rcv | output | 1 | Differential receiver output |
| slew_fs | output | 1 | Slew select, 1 = full-speed |
| susp_out | output | 1 | Suspend in effect |

## Verification
Two events can land in the same cycle: a line SE0, where RCV would hold, and the start of suspend, where RCV is forced low. The bench first sets RCV to 1 with a J state. It then raises the suspend pin on the same clock edge that the lines go to SE0, and expects RCV to read 0. It then releases suspend while SE0 persists and expects RCV to stay 0, because the hold keeps the forced value. A second case combines a wake request with suspend at low speed. There the lines must stay in the ordinary receive configuration.

// File: rtl/usbx_pkg.sv
package usbx_pkg;

  typedef struct packed {
    logic dir_m;
    logic dir_p;
    logic sw_susp;
    logic sw_spd;
    logic sw_ctl;
    logic gp_en;
    logic uart_en;
    logic enc_dse;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  typedef enum logic [2:0] {
    M_TX    = 3'd0,
    M_RX    = 3'd1,
    M_UART  = 3'd2,
    M_GPBUF = 3'd3,
    M_WAKE  = 3'd4
  } mode_e;

  typedef struct packed {
    logic dp_oe;
    logic dm_oe;
    logic dp;
    logic dm;
    logic pa_oe;
    logic pb_oe;
    logic pa;
    logic pb;
  } drv_t;

  function automatic logic pick_src(input logic sw, input logic reg_bit, input logic pin);
    return sw ? reg_bit : pin;
  endfunction

  function automatic logic line_se0(input logic dp, input logic dm);
    return !dp && !dm;
  endfunction

  function automatic logic rcv_eval(input logic dp, input logic dm,
                                    input logic susp, input logic prev);
    if (susp)          return 1'b0;
    else if (dp != dm) return dp;
    else               return prev;
  endfunction

  function automatic mode_e mode_eval(input cfg_t c, input logic rx, input logic wake_ok);
    if (c.uart_en)                        return M_UART;
    else if (c.gp_en && c.enc_dse && !rx) return M_GPBUF;
    else if (wake_ok)                     return M_WAKE;
    else if (rx)                          return M_RX;
    else                                  return M_TX;
  endfunction

endpackage

// File: rtl/usbx_ctl_sel.sv
module usbx_ctl_sel
  import usbx_pkg::*;
(
  input  cfg_t cfg,
  input  logic spd_pin,
  input  logic sus_pin,
  input  logic wake_req,
  output logic fs_eff,
  output logic susp_eff,
  output logic wake_ok
);
  always_comb begin
    fs_eff   = pick_src(cfg.sw_ctl, cfg.sw_spd,  spd_pin);
    susp_eff = pick_src(cfg.sw_ctl, cfg.sw_susp, sus_pin);
    wake_ok  = wake_req && susp_eff && fs_eff;
  end
endmodule

// File: rtl/usbx_rcv_track.sv
module usbx_rcv_track
  import usbx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dp,
  input  logic dm,
  input  logic susp,
  output logic rcv_d,
  output logic rcv_q
);
  assign rcv_d = rcv_eval(dp, dm, susp, rcv_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rcv_q <= 1'b0;
    else        rcv_q <= rcv_d;
  end
endmodule

// File: rtl/usbx_path_mux.sv
module usbx_path_mux
  import usbx_pkg::*;
(
  input  mode_e mode,
  input  cfg_t  cfg,
  input  logic  pa_in,
  input  logic  pb_in,
  input  logic  dp_in,
  input  logic  dm_in,
  input  logic  rcv_d,
  output drv_t  drv
);
  always_comb begin
    drv = '0;
    unique case (mode)
      M_TX: begin
        drv.dp_oe = 1'b1;
        drv.dm_oe = 1'b1;
        if (cfg.enc_dse) begin
          drv.dp = pb_in ? 1'b0 : pa_in;
          drv.dm = pb_in ? 1'b0 : !pa_in;
        end else begin
          drv.dp = pa_in;
          drv.dm = pb_in;
        end
      end
      M_RX: begin
        drv.pa_oe = 1'b1;
        drv.pb_oe = 1'b1;
        if (cfg.enc_dse) begin
          drv.pa = rcv_d;
          drv.pb = line_se0(dp_in, dm_in);
        end else begin
          drv.pa = dp_in;
          drv.pb = dm_in;
        end
      end
      M_UART: begin
        drv.pa_oe = 1'b1;
        drv.pa    = dp_in;
        drv.dm_oe = 1'b1;
        drv.dm    = pb_in;
      end
      M_GPBUF: begin
        if (cfg.dir_p) begin
          drv.dp_oe = 1'b1;
          drv.dp    = pa_in;
        end else begin
          drv.pa_oe = 1'b1;
          drv.pa    = dp_in;
        end
        if (cfg.dir_m) begin
          drv.dm_oe = 1'b1;
          drv.dm    = pb_in;
        end else begin
          drv.pb_oe = 1'b1;
          drv.pb    = dm_in;
        end
      end
      M_WAKE: begin
        drv.dp_oe = 1'b1;
        drv.dm_oe = 1'b1;
        drv.dp    = 1'b0;
        drv.dm    = 1'b1;
      end
      default: drv = '0;
    endcase
  end
endmodule

// File: rtl/usbx_mode_mux.sv
module usbx_mode_mux
  import usbx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             dir_rx,
  input  logic             spd_pin,
  input  logic             sus_pin,
  input  logic             wake_req,
  input  logic             pa_in,
  input  logic             pb_in,
  output logic             pa_out,
  output logic             pa_oe,
  output logic             pb_out,
  output logic             pb_oe,
  input  logic             dp_in,
  input  logic             dm_in,
  output logic             dp_out,
  output logic             dp_oe,
  output logic             dm_out,
  output logic             dm_oe,
  output logic             rcv,
  output logic             slew_fs,
  output logic             susp_out
);
  cfg_t  cfg_q;
  mode_e mode;
  logic  fs_eff, susp_eff, wake_ok;
  logic  rcv_d, rcv_q;
  drv_t  drv_d, drv_q;
  logic  fs_q, susp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cfg_q <= '0;
    else if (cfg_load) cfg_q <= cfg_t'(cfg_word);
  end

  usbx_ctl_sel u_ctl (
    .cfg      (cfg_q),
    .spd_pin  (spd_pin),
    .sus_pin  (sus_pin),
    .wake_req (wake_req),
    .fs_eff   (fs_eff),
    .susp_eff (susp_eff),
    .wake_ok  (wake_ok)
  );

  assign mode = mode_eval(cfg_q, dir_rx, wake_ok);

  usbx_rcv_track u_rcv (
    .clk   (clk),
    .rst_n (rst_n),
    .dp    (dp_in),
    .dm    (dm_in),
    .susp  (susp_eff),
    .rcv_d (rcv_d),
    .rcv_q (rcv_q)
  );

  usbx_path_mux u_mux (
    .mode  (mode),
    .cfg   (cfg_q),
    .pa_in (pa_in),
    .pb_in (pb_in),
    .dp_in (dp_in),
    .dm_in (dm_in),
    .rcv_d (rcv_d),
    .drv   (drv_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q  <= '0;
      fs_q   <= 1'b0;
      susp_q <= 1'b0;
    end else begin
      drv_q  <= drv_d;
      fs_q   <= fs_eff;
      susp_q <= susp_eff;
    end
  end

  assign pa_out   = drv_q.pa;
  assign pa_oe    = drv_q.pa_oe;
  assign pb_out   = drv_q.pb;
  assign pb_oe    = drv_q.pb_oe;
  assign dp_out   = drv_q.dp;
  assign dp_oe    = drv_q.dp_oe;
  assign dm_out   = drv_q.dm;
  assign dm_oe    = drv_q.dm_oe;
  assign rcv      = rcv_q;
  assign slew_fs  = fs_q;
  assign susp_out = susp_q;
endmodule

// File: rtl/usbx_mode_mux_chk.sv
module usbx_mode_mux_chk
  import usbx_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input cfg_t  cfg_q,
  input mode_e mode,
  input logic  susp_eff,
  input logic  pa_in,
  input logic  pb_in,
  input logic  dp_in,
  input logic  dm_in,
  input logic  pa_out,
  input logic  pa_oe,
  input logic  pb_out,
  input logic  pb_oe,
  input logic  dp_out,
  input logic  dp_oe,
  input logic  dm_out,
  input logic  dm_oe,
  input logic  rcv
);
  // R2
  se0_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_TX && cfg_q.enc_dse && pb_in) |=> (dp_oe && dm_oe && !dp_out && !dm_out));

  // R3
  vpvm_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_TX && !cfg_q.enc_dse) |=> (dp_out == $past(pa_in) && dm_out == $past(pb_in)));

  // R5
  vpvm_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_RX && !cfg_q.enc_dse) |=> (pa_out == $past(dp_in) && pb_out == $past(dm_in)));

  // R6
  rcv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!susp_eff && dp_in == dm_in) |=> $stable(rcv));

  // R7
  rcv_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    susp_eff |=> !rcv);

  // R9
  uart_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_UART) |=> (pa_oe && dm_oe && !dp_oe && !pb_oe));

  // R10
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pa_oe && dp_oe) && !(pb_oe && dm_oe));

  // R11
  wake_k_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_WAKE) |=> (dp_oe && dm_oe && !dp_out && dm_out));
endmodule

bind usbx_mode_mux usbx_mode_mux_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_q    (cfg_q),
  .mode     (mode),
  .susp_eff (susp_eff),
  .pa_in    (pa_in),
  .pb_in    (pb_in),
  .dp_in    (dp_in),
  .dm_in    (dm_in),
  .pa_out   (pa_out),
  .pa_oe    (pa_oe),
  .pb_out   (pb_out),
  .pb_oe    (pb_oe),
  .dp_out   (dp_out),
  .dp_oe    (dp_oe),
  .dm_out   (dm_out),
  .dm_oe    (dm_oe),
  .rcv      (rcv)
);

// File: tb/usbx_mode_mux_tb.sv
module usbx_mode_mux_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_load = 1'b0;
  logic [7:0] cfg_word = '0;
  logic dir_rx = 0, spd_pin = 0, sus_pin = 0, wake_req = 0;
  logic pa_in = 0, pb_in = 0, dp_in = 0, dm_in = 0;
  logic pa_out, pa_oe, pb_out, pb_oe, dp_out, dp_oe, dm_out, dm_oe;
  logic rcv, slew_fs, susp_out;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  usbx_mode_mux u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_word(cfg_word),
    .dir_rx(dir_rx), .spd_pin(spd_pin), .sus_pin(sus_pin), .wake_req(wake_req),
    .pa_in(pa_in), .pb_in(pb_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_out(pb_out), .pb_oe(pb_oe), .dp_in(dp_in), .dm_in(dm_in),
    .dp_out(dp_out), .dp_oe(dp_oe), .dm_out(dm_out), .dm_oe(dm_oe),
    .rcv(rcv), .slew_fs(slew_fs), .susp_out(susp_out)
  );

  // {cfg[7:0], dir_rx, pa, pb, dp, dm, spd, sus, wake,
  //  expect: dp_oe, dm_oe, dp, dm, pa_oe, pb_oe, pa, pb, slew_fs, susp_out}
  localparam int NV = 22;
  localparam logic [25:0] VEC [NV] = '{
    {8'h01, 8'b0_1_0_0_0_1_0_0, 10'b1_1_1_0_0_0_0_0_1_0}, // R2 J
    {8'h01, 8'b0_0_0_0_0_0_0_0, 10'b1_1_0_1_0_0_0_0_0_0}, // R2 K
    {8'h01, 8'b0_1_1_0_0_1_0_0, 10'b1_1_0_0_0_0_0_0_1_0}, // R2 SE0 wins
    {8'h00, 8'b0_1_1_0_0_1_0_0, 10'b1_1_1_1_0_0_0_0_1_0}, // R3
    {8'h00, 8'b0_0_1_0_0_1_0_0, 10'b1_1_0_1_0_0_0_0_1_0}, // R3
    {8'h01, 8'b1_0_0_1_0_1_0_0, 10'b0_0_0_0_1_1_1_0_1_0}, // R4
    {8'h01, 8'b1_0_0_0_1_1_0_0, 10'b0_0_0_0_1_1_0_0_1_0}, // R4
    {8'h00, 8'b1_0_0_1_0_1_0_0, 10'b0_0_0_0_1_1_1_0_1_0}, // R5
    {8'h00, 8'b1_0_0_0_1_1_0_0, 10'b0_0_0_0_1_1_0_1_1_0}, // R5
    {8'h19, 8'b0_1_0_0_0_0_1_0, 10'b1_1_1_0_0_0_0_0_1_0}, // R8 pins ignored
    {8'h29, 8'b0_1_0_0_0_1_0_0, 10'b1_1_1_0_0_0_0_0_0_1}, // R8 sw suspend
    {8'h01, 8'b0_0_0_0_0_1_1_0, 10'b1_1_0_1_0_0_0_0_1_1}, // R8 hw suspend
    {8'h02, 8'b0_0_0_1_0_1_0_0, 10'b0_1_0_0_1_0_1_0_1_0}, // R9
    {8'h03, 8'b1_0_1_0_0_1_0_0, 10'b0_1_0_1_1_0_0_0_1_0}, // R9 dir ignored
    {8'h45, 8'b0_1_0_0_1_1_0_0, 10'b1_0_1_0_0_1_0_1_1_0}, // R10 D+ out, D- in
    {8'h85, 8'b0_0_0_1_0_1_0_0, 10'b0_1_0_0_1_0_1_0_1_0}, // R10 D+ in, D- out
    {8'h45, 8'b1_0_0_1_0_1_0_0, 10'b0_0_0_0_1_1_1_0_1_0}, // R10 blocked by dir_rx
    {8'h44, 8'b0_0_0_0_0_1_0_0, 10'b1_1_0_0_0_0_0_0_1_0}, // R10 blocked by enc
    {8'h47, 8'b0_0_1_1_0_1_0_0, 10'b0_1_0_1_1_0_1_0_1_0}, // R10 blocked by uart
    {8'h39, 8'b1_0_0_1_0_0_0_1, 10'b1_1_0_1_0_0_0_0_1_1}, // R11 wake at FS
    {8'h29, 8'b1_0_0_1_0_1_0_1, 10'b0_0_0_0_1_1_0_0_0_1}, // R11 no wake at LS
    {8'h19, 8'b1_0_0_0_1_0_0_1, 10'b0_0_0_0_1_1_0_0_1_0}  // R11 no wake awake
  };

  function automatic string req_of(input int i);
    case (i)
      0, 1, 2:                return "R2";
      3, 4:                   return "R3";
      5, 6:                   return "R4";
      7, 8:                   return "R5";
      9, 10, 11:              return "R8";
      12, 13:                 return "R9";
      14, 15, 16, 17, 18:     return "R10";
      default:                return "R11";
    endcase
  endfunction

  function automatic logic [9:0] outs();
    return {dp_oe, dm_oe, dp_out, dm_out, pa_oe, pb_oe, pa_out, pb_out, slew_fs, susp_out};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic set_in(input logic [7:0] b);
    {dir_rx, pa_in, pb_in, dp_in, dm_in, spd_pin, sus_pin, wake_req} = b;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {5'b0, rcv, outs()}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 configuration after reset is zero: hw control, VP/VM encoding
    set_in(8'b0_1_0_0_0_1_0_0);
    @(negedge clk); @(negedge clk);
    check("R1", {6'b0, outs()}, {6'b0, 10'b1_1_1_0_0_0_0_0_1_0});

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cfg_word = VEC[i][25:18];
      cfg_load = 1'b1;
      set_in(VEC[i][17:10]);
      @(negedge clk);
      cfg_load = 1'b0;
      @(negedge clk);
      check(req_of(i), {6'b0, outs()}, {6'b0, VEC[i][9:0]});
    end

    // R6 hold through SE0, data/SE0 receive, hw control
    @(negedge clk);
    cfg_word = 8'h01; cfg_load = 1'b1;
    set_in(8'b1_0_0_1_0_1_0_0);
    @(negedge clk); cfg_load = 1'b0;
    @(negedge clk);
    check("R6", {15'b0, rcv}, 16'd1);
    dp_in = 0; dm_in = 0;
    @(negedge clk);
    check("R6", {13'b0, rcv, pa_out, pb_out}, {13'b0, 3'b111});
    dp_in = 1; dm_in = 1;
    @(negedge clk);
    check("R6", {15'b0, rcv}, 16'd1);
    dp_in = 0; dm_in = 1;
    @(negedge clk);
    check("R6", {15'b0, rcv}, 16'd0);
    dp_in = 0; dm_in = 0;
    @(negedge clk);
    check("R6", {15'b0, rcv}, 16'd0);

    // R7 suspend and SE0 arriving on the same edge
    dp_in = 1; dm_in = 0;
    @(negedge clk);
    check("R7", {15'b0, rcv}, 16'd1);
    dp_in = 0; dm_in = 0; sus_pin = 1;
    @(negedge clk);
    check("R7", {14'b0, rcv, susp_out}, 16'b01);
    sus_pin = 0;
    @(negedge clk);
    check("R7", {14'b0, rcv, susp_out}, 16'b00);
    dp_in = 1; sus_pin = 1;
    @(negedge clk);
    check("R7", {15'b0, rcv}, 16'd0);
    sus_pin = 0;

    // R12 one-edge latency
    @(negedge clk);
    cfg_word = 8'h00; cfg_load = 1'b1; set_in(8'b0_0_0_0_0_1_0_0);
    @(negedge clk); cfg_load = 1'b0;
    @(negedge clk);
    pa_in = 1;
    #2;
    check("R12", {15'b0, dp_out}, 16'd0);
    @(negedge clk);
    check("R12", {15'b0, dp_out}, 16'd1);

    // R1 asynchronous reset mid-run
    #3 rst_n = 1'b0;
    #2;
    check("R1", {5'b0, rcv, outs()}, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule